// File: doc/BRIEF.md
# Fault-Injection Delay Sweep Sequencer

This block automates a timing scan for fault-injection experiments. Software sets a window of injection delays, a step, a count of trials per delay, a pulse width and a settle timeout, then strobes start. The sequencer takes the target through a fixed series of steps for each trial. It holds the target in reset, issues a one-cycle launch, waits the current delay, and drives the trigger pulse for the programmed width. It then waits the timeout, asserts halt for one cycle and captures the target's status word. At the end of each trial it offers a result record on a valid/ready stream.

Before the sweep proper, the block runs one calibration trial. This trial has the same timing, but the trigger pulse is held low. The status captured during calibration becomes the golden reference, and every later record carries a flag that marks a difference from it. The block also sorts each captured status into one of three outcomes: normal completion, trapped in a handler, or crashed. All durations are counted in clock cycles.

Top module: `glitch_sweep_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `recValid` and all four target outputs are low.
- R2: A start strobe while idle latches all configuration inputs. `busy` is high from the next cycle until the cycle after the final record is accepted. While busy, a start strobe is ignored, and changes to the configuration inputs do not alter the running sweep.
- R3: The first trial is a calibration trial. It has the same timing as other trials, with the delay set to the window start, but `glitchPulse` stays low. Its record has outcome 2'b11, delay equal to the window start, trial index 0 and mismatch 0. The status it captures becomes the golden reference.
- R4: Each trial follows this order:
  - `tgtReset` high for RST_LEN cycles.
  - `tgtLaunch` high for one cycle.
  - A wait of D cycles.
  - A pulse phase of W cycles.
  - A wait phase of T cycles.
  - `tgtHalt` high for one cycle.
  
  `tgtStatus` is sampled at the end of the halt cycle.
- R5: `glitchPulse` rises exactly D+1 cycles after the launch cycle. With D = 0 it directly follows launch. It stays high for the programmed width, and a width of 0 acts as 1. A timeout of 0 acts as 1.
- R6: Each delay value is tried `cfgRepeat` times, with trial indices 0 to `cfgRepeat`-1. A count of 0 acts as 1.
- R7: Delays run from the window start upward in steps of `cfgStep`, as long as the value does not exceed the window end. A step of 0 acts as 1. A start above the end runs the start value only. The sum is taken without wraparound, so a sum beyond 32 bits ends the sweep.
- R8: The outcome code is 2'b00 when status bit 0 is set. It is 2'b01 when bit 0 is clear and bit 1 is set. It is 2'b10 when both bits are clear.
- R9: `recMismatch` is high when the whole captured status word differs from the golden status.
- R10: A record stays valid and stable until `recReady`. The next trial's reset begins in the cycle after acceptance.
- R11: `done` is a one-cycle pulse in the cycle after the last record is accepted. `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStrobe | input | 1 | Begin a sweep |
| cfgDelayMin | input | CNT_W | First injection delay, cycles |
| cfgDelayMax | input | CNT_W | Last allowed injection delay, cycles |
| cfgStep | input | CNT_W | Delay increment |
| cfgRepeat | input | TRIAL_W | Trials per delay |
| cfgWidth | input | CNT_W | Trigger pulse width, cycles |
| cfgTimeout | input | CNT_W | Settle time after the pulse, cycles |
| tgtStatus | input | STATUS_W | Target status word; bit 0 completion, bit 1 handler |
| recReady | input | 1 | Record stream ready |
| tgtReset | output | 1 | Target reset |
| tgtLaunch | output | 1 | Target launch strobe |
| glitchPulse | output | 1 | Trigger pulse to the injector |
| tgtHalt | output | 1 | Target halt |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished pulse |
| recValid | output | 1 | Record valid |
| recDelay | output | CNT_W | Record delay value |
| recTrial | output | TRIAL_W | Record trial index |
| recOutcome | output | 2 | Record outcome code |
| recMismatch | output | 1 | Status differs from golden |

## Verification
The assertions assume that `recReady` is a plain level, and that `tgtStatus` is meaningful only while `tgtHalt` is high. They place no bound on the configuration values. The stimulus changes `tgtStatus` to a decoy value outside the halt cycle, so a capture in the wrong cycle shows up. It throttles `recReady` with a repeating pattern. It also alters the configuration and pulses start in the middle of a sweep. Configuration sets are kept small enough for each sweep to last a few hundred cycles. They still cover the zero-valued step, count, width and timeout, a window start above its end, and a step large enough to overflow 32 bits.

// File: rtl/gss_pkg.sv
package gss_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_LAUNCH, S_DLY, S_PULSE, S_WAIT, S_HALT, S_EMIT
  } seq_state_t;

  typedef struct packed {
    logic latchCfg;
    logic capture;
    logic advance;
  } seq_strobe_t;

  localparam logic [1:0] OUT_NORMAL = 2'b00;
  localparam logic [1:0] OUT_TRAP   = 2'b01;
  localparam logic [1:0] OUT_CRASH  = 2'b10;
  localparam logic [1:0] OUT_CAL    = 2'b11;
endpackage

// File: rtl/gss_ctrl.sv
module gss_ctrl
  import gss_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int RST_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStrobe,
  input  logic             recReady,
  input  logic [CNT_W-1:0] dlyCycles,
  input  logic [CNT_W-1:0] widthCycles,
  input  logic [CNT_W-1:0] timeoutCycles,
  input  logic             isCal,
  input  logic             lastTrial,
  input  logic             lastDelay,
  output seq_strobe_t      strb,
  output logic             tgtReset,
  output logic             tgtLaunch,
  output logic             glitchPulse,
  output logic             tgtHalt,
  output logic             recValid,
  output logic             busy,
  output logic             done
);
  localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'(RST_LEN - 1);

  seq_state_t state;
  logic [CNT_W-1:0] cnt;
  logic sweepEnd;

  assign sweepEnd = !isCal && lastTrial && lastDelay;

  always_comb begin
    strb.latchCfg = (state == S_IDLE) && startStrobe;
    strb.capture  = (state == S_HALT);
    strb.advance  = (state == S_EMIT) && recReady;
  end

  assign tgtReset    = (state == S_RST);
  assign tgtLaunch   = (state == S_LAUNCH);
  assign glitchPulse = (state == S_PULSE) && !isCal;
  assign tgtHalt     = (state == S_HALT);
  assign recValid    = (state == S_EMIT);
  assign busy        = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (startStrobe) begin
          state <= S_RST;
          cnt   <= RST_LOAD;
        end
        S_RST: if (cnt == '0) state <= S_LAUNCH; else cnt <= cnt - 1'b1;
        S_LAUNCH: begin
          if (dlyCycles == '0) begin
            state <= S_PULSE;
            cnt   <= widthCycles - 1'b1;
          end else begin
            state <= S_DLY;
            cnt   <= dlyCycles - 1'b1;
          end
        end
        S_DLY: if (cnt == '0) begin
          state <= S_PULSE;
          cnt   <= widthCycles - 1'b1;
        end else cnt <= cnt - 1'b1;
        S_PULSE: if (cnt == '0) begin
          state <= S_WAIT;
          cnt   <= timeoutCycles - 1'b1;
        end else cnt <= cnt - 1'b1;
        S_WAIT: if (cnt == '0) state <= S_HALT; else cnt <= cnt - 1'b1;
        S_HALT: state <= S_EMIT;
        S_EMIT: if (recReady) begin
          if (sweepEnd) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            state <= S_RST;
            cnt   <= RST_LOAD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gss_dpath.sv
module gss_dpath
  import gss_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int TRIAL_W  = 16,
  parameter int STATUS_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  seq_strobe_t         strb,
  input  logic [CNT_W-1:0]    cfgDelayMin,
  input  logic [CNT_W-1:0]    cfgDelayMax,
  input  logic [CNT_W-1:0]    cfgStep,
  input  logic [TRIAL_W-1:0]  cfgRepeat,
  input  logic [CNT_W-1:0]    cfgWidth,
  input  logic [CNT_W-1:0]    cfgTimeout,
  input  logic [STATUS_W-1:0] tgtStatus,
  output logic [CNT_W-1:0]    dlyCycles,
  output logic [CNT_W-1:0]    widthCycles,
  output logic [CNT_W-1:0]    timeoutCycles,
  output logic                isCal,
  output logic                lastTrial,
  output logic                lastDelay,
  output logic [TRIAL_W-1:0]  recTrial,
  output logic [1:0]          recOutcome,
  output logic                recMismatch
);
  logic [CNT_W-1:0]    maxReg, stepReg, curDelay;
  logic [TRIAL_W-1:0]  repReg, trialIdx;
  logic [STATUS_W-1:0] capStatus, golden;
  logic [CNT_W:0]      nextSum;

  assign nextSum   = {1'b0, curDelay} + {1'b0, stepReg};
  assign lastDelay = nextSum > {1'b0, maxReg};
  assign lastTrial = (trialIdx == repReg - 1'b1);
  assign dlyCycles = curDelay;
  assign recTrial  = trialIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maxReg <= '0; stepReg <= '0; curDelay <= '0;
      repReg <= '0; trialIdx <= '0; isCal <= 1'b0;
      widthCycles <= '0; timeoutCycles <= '0;
      capStatus <= '0; golden <= '0;
    end else begin
      if (strb.latchCfg) begin
        curDelay      <= cfgDelayMin;
        maxReg        <= cfgDelayMax;
        stepReg       <= (cfgStep == '0) ? CNT_W'(1) : cfgStep;
        repReg        <= (cfgRepeat == '0) ? TRIAL_W'(1) : cfgRepeat;
        widthCycles   <= (cfgWidth == '0) ? CNT_W'(1) : cfgWidth;
        timeoutCycles <= (cfgTimeout == '0) ? CNT_W'(1) : cfgTimeout;
        trialIdx      <= '0;
        isCal         <= 1'b1;
      end
      if (strb.capture) begin
        capStatus <= tgtStatus;
        if (isCal) golden <= tgtStatus;
      end
      if (strb.advance) begin
        if (isCal) begin
          isCal <= 1'b0;
        end else if (!lastTrial) begin
          trialIdx <= trialIdx + 1'b1;
        end else begin
          trialIdx <= '0;
          curDelay <= nextSum[CNT_W-1:0];
        end
      end
    end
  end

  always_comb begin
    if (isCal)             recOutcome = OUT_CAL;
    else if (capStatus[0]) recOutcome = OUT_NORMAL;
    else if (capStatus[1]) recOutcome = OUT_TRAP;
    else                   recOutcome = OUT_CRASH;
  end

  assign recMismatch = !isCal && (capStatus != golden);
endmodule

// File: rtl/glitch_sweep_seq.sv
module glitch_sweep_seq
  import gss_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int TRIAL_W  = 16,
  parameter int STATUS_W = 8,
  parameter int RST_LEN  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startStrobe,
  input  logic [CNT_W-1:0]    cfgDelayMin,
  input  logic [CNT_W-1:0]    cfgDelayMax,
  input  logic [CNT_W-1:0]    cfgStep,
  input  logic [TRIAL_W-1:0]  cfgRepeat,
  input  logic [CNT_W-1:0]    cfgWidth,
  input  logic [CNT_W-1:0]    cfgTimeout,
  input  logic [STATUS_W-1:0] tgtStatus,
  input  logic                recReady,
  output logic                tgtReset,
  output logic                tgtLaunch,
  output logic                glitchPulse,
  output logic                tgtHalt,
  output logic                busy,
  output logic                done,
  output logic                recValid,
  output logic [CNT_W-1:0]    recDelay,
  output logic [TRIAL_W-1:0]  recTrial,
  output logic [1:0]          recOutcome,
  output logic                recMismatch
);
  seq_strobe_t      strb;
  logic [CNT_W-1:0] dlyCycles, widthCycles, timeoutCycles;
  logic             isCal, lastTrial, lastDelay;

  assign recDelay = dlyCycles;

  gss_ctrl #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_ctrl (
    .clk, .rstN, .startStrobe, .recReady,
    .dlyCycles, .widthCycles, .timeoutCycles,
    .isCal, .lastTrial, .lastDelay, .strb,
    .tgtReset, .tgtLaunch, .glitchPulse, .tgtHalt,
    .recValid, .busy, .done
  );

  gss_dpath #(.CNT_W(CNT_W), .TRIAL_W(TRIAL_W), .STATUS_W(STATUS_W)) u_dpath (
    .clk, .rstN, .strb,
    .cfgDelayMin, .cfgDelayMax, .cfgStep, .cfgRepeat, .cfgWidth, .cfgTimeout,
    .tgtStatus, .dlyCycles, .widthCycles, .timeoutCycles,
    .isCal, .lastTrial, .lastDelay, .recTrial, .recOutcome, .recMismatch
  );
endmodule

// File: rtl/gss_chk.sv
module gss_chk #(
  parameter int CNT_W   = 32,
  parameter int TRIAL_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               recReady,
  input logic               tgtReset,
  input logic               tgtLaunch,
  input logic               glitchPulse,
  input logic               tgtHalt,
  input logic               busy,
  input logic               done,
  input logic               recValid,
  input logic [CNT_W-1:0]   recDelay,
  input logic [TRIAL_W-1:0] recTrial,
  input logic [1:0]         recOutcome,
  input logic               recMismatch
);
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({tgtReset, tgtLaunch, glitchPulse, tgtHalt, recValid})); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(tgtReset || tgtLaunch || glitchPulse || tgtHalt || recValid)); // R1
  AST_LAUNCH_AFTER_RST: assert property (@(posedge clk) disable iff (!rstN)
    tgtLaunch |-> $past(tgtReset)); // R4
  AST_REC_AFTER_HALT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(recValid) |-> $past(tgtHalt)); // R4
  AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    recValid && !recReady |=> recValid && $stable(recDelay) && $stable(recTrial)
      && $stable(recOutcome) && $stable(recMismatch)); // R10
  AST_CAL_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    recValid && recOutcome == 2'b11 |-> !recMismatch && recTrial == '0); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(recValid && recReady)); // R11
endmodule

bind glitch_sweep_seq gss_chk #(.CNT_W(CNT_W), .TRIAL_W(TRIAL_W)) u_chk (
  .clk(clk), .rstN(rstN), .recReady(recReady),
  .tgtReset(tgtReset), .tgtLaunch(tgtLaunch), .glitchPulse(glitchPulse),
  .tgtHalt(tgtHalt), .busy(busy), .done(done), .recValid(recValid),
  .recDelay(recDelay), .recTrial(recTrial), .recOutcome(recOutcome),
  .recMismatch(recMismatch)
);

// File: tb/glitch_sweep_seq_tb.sv
module glitch_sweep_seq_tb;
  localparam int CNT_W = 32, TRIAL_W = 16, STATUS_W = 8, RST_LEN = 4;

  logic clk = 1'b0, rstN = 1'b0, startStrobe = 1'b0, recReady = 1'b0;
  logic [CNT_W-1:0] cfgDelayMin = '0, cfgDelayMax = '0, cfgStep = '0;
  logic [CNT_W-1:0] cfgWidth = '0, cfgTimeout = '0;
  logic [TRIAL_W-1:0] cfgRepeat = '0;
  logic [STATUS_W-1:0] tgtStatus = 8'hEE;
  logic tgtReset, tgtLaunch, glitchPulse, tgtHalt, busy, done, recValid, recMismatch;
  logic [CNT_W-1:0] recDelay;
  logic [TRIAL_W-1:0] recTrial;
  logic [1:0] recOutcome;

  glitch_sweep_seq #(.CNT_W(CNT_W), .TRIAL_W(TRIAL_W), .STATUS_W(STATUS_W),
    .RST_LEN(RST_LEN)) u_dut (.*);

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0, rdyCnt = 0;
  bit idlePhase = 1'b1, injectStart = 1'b0, checking = 1'b0;
  logic eRst, eLaunch, ePulse, eHalt, eBusy, eDone, eValid, eMis;
  logic [CNT_W-1:0] eDelay;
  logic [TRIAL_W-1:0] eTrial;
  logic [1:0] eOut;
  logic [STATUS_W-1:0] golden;

  task automatic chk(string req, string nm, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, nm, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (checking) begin
    chk(idlePhase ? "R1" : "R4", "tgtReset", tgtReset, eRst);
    chk(idlePhase ? "R1" : "R4", "tgtLaunch", tgtLaunch, eLaunch);
    chk(idlePhase ? "R1" : "R5", "glitchPulse", glitchPulse, ePulse);
    chk(idlePhase ? "R1" : "R4", "tgtHalt", tgtHalt, eHalt);
    chk(idlePhase ? "R1" : "R2", "busy", busy, eBusy);
    chk("R11", "done", done, eDone);
    chk("R10", "recValid", recValid, eValid);
    if (eValid) begin
      chk("R7", "recDelay", recDelay, eDelay);
      chk("R6", "recTrial", recTrial, eTrial);
      chk("R8", "recOutcome", recOutcome, eOut);
      chk("R9", "recMismatch", recMismatch, eMis);
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      compared++;
      $display("FAIL R2 watchdog actual=%0d expected=<150000", cycles);
      summary();
    end
  end

  task automatic setExp(logic r, logic l, logic p, logic h, logic b, logic d, logic v);
    eRst = r; eLaunch = l; ePulse = p; eHalt = h; eBusy = b; eDone = d; eValid = v;
  endtask

  task automatic step(logic r, logic l, logic p, logic h, logic b, logic d, logic v);
    @(posedge clk); #1;
    startStrobe = 1'b0;
    tgtStatus = 8'hEE;  // decoy outside the halt cycle
    setExp(r, l, p, h, b, d, v);
  endtask

  function automatic logic [7:0] statusFor(longint d, int t);
    case ((d + t) % 4)
      0: return 8'hA1;
      1: return 8'hB1;
      2: return 8'h02;
      default: return 8'h40;
    endcase
  endfunction

  task automatic doTrial(bit cal, longint d, int t, int w1, int t1);
    logic [7:0] s;
    bit rdy;
    s = cal ? 8'hA1 : statusFor(d, t);
    repeat (RST_LEN) step(1, 0, 0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 1, 0, 0);  // R4 launch
    if (injectStart) begin  // R2: ignored strobe and config change
      injectStart = 1'b0;
      startStrobe = 1'b1;
      cfgDelayMax = 32'd1000; cfgRepeat = 16'd7; cfgWidth = 32'd9; cfgTimeout = 32'd30;
    end
    for (longint i = 0; i < d; i++) step(0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < w1; i++) step(0, 0, !cal, 0, 1, 0, 0);  // R5, R3 no pulse
    for (int i = 0; i < t1; i++) step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 1, 0, 0);
    tgtStatus = s;
    if (cal) golden = s;
    eDelay = CNT_W'(d); eTrial = TRIAL_W'(t);
    eOut = cal ? 2'b11 : (s[0] ? 2'b00 : (s[1] ? 2'b01 : 2'b10));
    eMis = !cal && (s != golden);
    do begin
      step(0, 0, 0, 0, 1, 0, 1);
      rdyCnt++;
      rdy = (rdyCnt % 3) != 1;
      recReady = rdy;
    end while (!rdy);
  endtask

  task automatic runSweep(longint mn, longint mx, longint st, int rep, int w, int to, bit inj);
    longint st1, d;
    int rep1, w1, t1;
    cfgDelayMin = CNT_W'(mn); cfgDelayMax = CNT_W'(mx); cfgStep = CNT_W'(st);
    cfgRepeat = TRIAL_W'(rep); cfgWidth = CNT_W'(w); cfgTimeout = CNT_W'(to);
    st1 = (st == 0) ? 1 : st; rep1 = (rep == 0) ? 1 : rep;
    w1 = (w == 0) ? 1 : w; t1 = (to == 0) ? 1 : to;
    injectStart = inj;
    startStrobe = 1'b1;
    idlePhase = 1'b0;
    doTrial(1, mn, 0, w1, t1);  // R3 calibration
    d = mn;
    forever begin
      for (int t = 0; t < rep1; t++) doTrial(0, d, t, w1, t1);  // R6
      if (d + st1 > mx) break;  // R7
      d += st1;
    end
    step(0, 0, 0, 0, 0, 1, 0);  // R11 done pulse
    idlePhase = 1'b1;
    recReady = 1'b0;
    repeat (3) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    setExp(0, 0, 0, 0, 0, 0, 0);
    eDelay = '0; eTrial = '0; eOut = '0; eMis = 1'b0; golden = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    checking = 1'b1;
    repeat (3) step(0, 0, 0, 0, 0, 0, 0);  // R1 reset state
    runSweep(3, 9, 3, 2, 2, 5, 1'b1);                    // R2, R6, R7 basic sweep
    runSweep(0, 5, 0, 1, 0, 0, 1'b0);                    // R5, R7 zero step/width/timeout
    runSweep(10, 12, 5, 0, 3, 2, 1'b0);                  // R6 zero repeat, R7 one value
    runSweep(7, 3, 1, 3, 1, 1, 1'b0);                    // R7 start above end
    runSweep(5, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1, 2, 1, 1'b0);  // R7 overflow ends sweep
    summary();
  end
endmodule